// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Control

This block decides, in a five-stage in-order pipeline, where each of the two ALU operands of the instruction in the execute stage comes from. Each operand can take the register-file value captured at decode, the result in the execute/memory pipeline register, or the value in the memory/writeback pipeline register. When both later stages hold a pending write to the same register, the younger one wins. Register-register results therefore reach a dependent instruction without any stall.

The only hazard that bypassing cannot cover is a load followed at once by an instruction that needs the loaded value. The data of a load exists only after the memory stage. When such a pair is seen, the block asks the front end to hold the program counter and the fetch/decode register for one cycle and asks for a bubble in the decode/execute register. One cycle later the load sits in memory/writeback, and the dependent instruction takes its value from there through the normal bypass path. The block is pure control: it reads register numbers, write enables, load flags and valid bits, and it drives select codes and two stall strobes.

Top module: `fwd_interlock_unit`

## Requirements
- R1: Each operand select is a 2-bit code. 00 picks the register file, 10 picks the execute/memory result and 01 picks the memory/writeback value. The code 11 never appears.
- R2: An operand whose source register equals the destination of a valid, writing instruction in execute/memory selects 10.
- R3: An operand that matches only a valid, writing instruction in memory/writeback selects 01.
- R4: When both later stages write the operand's source register, the select is 10, the younger producer.
- R5: Register 0 is never bypassed and never causes a stall. Its select is 00.
- R6: A stage whose write enable or valid bit is low takes no part in bypassing or in the load-use check.
- R7: If a valid load with a non-zero destination is in decode/execute, and that destination matches a source that the valid decode instruction reads, then freeze and bubble are both 1 in that same cycle.
- R8: A source that the decode instruction does not read (its used flag is 0) never causes a stall, even if its register number matches.
- R9: A non-load instruction in decode/execute never causes a stall, so dependent ALU instructions placed next to each other run with no stall.
- R10: Operand A follows the first source (rs) and operand B follows the second source (rt). The two selects are computed independently.
- R11: In the sequence load, bubble, consumer, the consumer's operand selects 01 once the load reaches memory/writeback, and no second stall is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the checks |
| rst | input | 1 | Synchronous active-high reset, disables the checks |
| dec_valid | input | 1 | Decode-stage (fetch/decode register) instruction is valid |
| dec_rs | input | REG_W | Decode-stage first source register |
| dec_rs_used | input | 1 | Decode instruction reads its first source |
| dec_rt | input | REG_W | Decode-stage second source register |
| dec_rt_used | input | 1 | Decode instruction reads its second source (including store data) |
| exe_valid | input | 1 | Decode/execute register holds a valid instruction |
| exe_wen | input | 1 | That instruction writes a register |
| exe_load | input | 1 | That instruction is a load |
| exe_rd | input | REG_W | Its destination register |
| exe_rs | input | REG_W | Its first source, for operand A |
| exe_rt | input | REG_W | Its second source, for operand B |
| mem_valid | input | 1 | Execute/memory register holds a valid instruction |
| mem_wen | input | 1 | That instruction writes a register |
| mem_rd | input | REG_W | Its destination register |
| wb_valid | input | 1 | Memory/writeback register holds a valid instruction |
| wb_wen | input | 1 | That instruction writes a register |
| wb_rd | input | REG_W | Its destination register |
| sel_a | output | 2 | Operand A source code |
| sel_b | output | 2 | Operand B source code |
| freeze_front | output | 1 | Hold the PC and the fetch/decode register |
| bubble_exe | output | 1 | Load a no-op into the decode/execute register |

## Verification
The bench aims at double writers, where a design that lets the older writer win would hand the consumer a stale value. It also aims at register 0 and at disabled or invalid writers, where a sloppy compare would bypass garbage or stall for nothing. A stall raised by an unused second source, or by a non-load producer, costs cycles without changing the results, so it appears only on the freeze and bubble outputs, which are checked every cycle. The load, bubble, consumer sequence confirms that the stall is followed by a bypass from memory/writeback and not by a second stall.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    typedef enum logic [1:0] {
        SRC_REGFILE = 2'b00,
        SRC_LATEWB  = 2'b01,
        SRC_EARLY   = 2'b10
    } opnd_src_e;

    localparam int NUM_OPND = 2;

    function automatic logic live_write(input logic valid, input logic wen);
        return valid & wen;
    endfunction

endpackage

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
    import fwd_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] src,
    input  logic             early_live,
    input  logic [REG_W-1:0] early_rd,
    input  logic             late_live,
    input  logic [REG_W-1:0] late_rd,
    output opnd_src_e        sel
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    logic src_nz;
    logic hit_early;
    logic hit_late;

    always_comb begin
        src_nz    = (src != ZERO_REG);
        hit_early = src_nz && early_live && (early_rd == src);
        hit_late  = src_nz && late_live  && (late_rd  == src);
        if (hit_early)
            sel = SRC_EARLY;
        else if (hit_late)
            sel = SRC_LATEWB;
        else
            sel = SRC_REGFILE;
    end

    // R1: the code 11 must never leave this block
    a_r1_code_legal: assert property (@(posedge clk) disable iff (rst)
        sel != 2'b11);

    // R5: register 0 always reads the register file
    a_r5_zero_regfile: assert property (@(posedge clk) disable iff (rst)
        (src == ZERO_REG) |-> (sel == SRC_REGFILE));

    // R4: the younger writer takes priority over the older one
    a_r4_younger_wins: assert property (@(posedge clk) disable iff (rst)
        (early_live && late_live && early_rd == late_rd && early_rd == src && src != ZERO_REG)
        |-> (sel == SRC_EARLY));

endmodule

// File: rtl/fwd_loaduse_detect.sv
module fwd_loaduse_detect
    import fwd_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dec_valid,
    input  logic [REG_W-1:0] dec_rs,
    input  logic             dec_rs_used,
    input  logic [REG_W-1:0] dec_rt,
    input  logic             dec_rt_used,
    input  logic             exe_valid,
    input  logic             exe_wen,
    input  logic             exe_load,
    input  logic [REG_W-1:0] exe_rd,
    output logic             stall
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    logic load_live;
    logic rs_dep;
    logic rt_dep;

    always_comb begin
        load_live = live_write(exe_valid, exe_wen) && exe_load && (exe_rd != ZERO_REG);
        rs_dep    = dec_rs_used && (dec_rs == exe_rd);
        rt_dep    = dec_rt_used && (dec_rt == exe_rd);
        stall     = dec_valid && load_live && (rs_dep || rt_dep);
    end

    // R9: only a load in decode/execute can stall
    a_r9_load_only: assert property (@(posedge clk) disable iff (rst)
        stall |-> (exe_load && exe_valid && exe_wen));

    // R5: a load to register 0 never stalls
    a_r5_zero_nostall: assert property (@(posedge clk) disable iff (rst)
        (exe_rd == ZERO_REG) |-> !stall);

    // R8: an unread source match alone never stalls
    a_r8_unused_src: assert property (@(posedge clk) disable iff (rst)
        (!dec_rs_used && !dec_rt_used) |-> !stall);

endmodule

// File: rtl/fwd_interlock_unit.sv
module fwd_interlock_unit
    import fwd_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dec_valid,
    input  logic [REG_W-1:0] dec_rs,
    input  logic             dec_rs_used,
    input  logic [REG_W-1:0] dec_rt,
    input  logic             dec_rt_used,
    input  logic             exe_valid,
    input  logic             exe_wen,
    input  logic             exe_load,
    input  logic [REG_W-1:0] exe_rd,
    input  logic [REG_W-1:0] exe_rs,
    input  logic [REG_W-1:0] exe_rt,
    input  logic             mem_valid,
    input  logic             mem_wen,
    input  logic [REG_W-1:0] mem_rd,
    input  logic             wb_valid,
    input  logic             wb_wen,
    input  logic [REG_W-1:0] wb_rd,
    output logic [1:0]       sel_a,
    output logic [1:0]       sel_b,
    output logic             freeze_front,
    output logic             bubble_exe
);
    logic             early_live;
    logic             late_live;
    logic [REG_W-1:0] opnd_src [NUM_OPND];
    opnd_src_e        opnd_sel [NUM_OPND];
    logic             lu_stall;

    assign early_live  = live_write(mem_valid, mem_wen);
    assign late_live   = live_write(wb_valid, wb_wen);
    assign opnd_src[0] = exe_rs;
    assign opnd_src[1] = exe_rt;

    for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
        fwd_operand_sel #(.REG_W(REG_W)) u_sel (
            .clk        (clk),
            .rst        (rst),
            .src        (opnd_src[g]),
            .early_live (early_live),
            .early_rd   (mem_rd),
            .late_live  (late_live),
            .late_rd    (wb_rd),
            .sel        (opnd_sel[g])
        );
    end

    fwd_loaduse_detect #(.REG_W(REG_W)) u_lu (
        .clk         (clk),
        .rst         (rst),
        .dec_valid   (dec_valid),
        .dec_rs      (dec_rs),
        .dec_rs_used (dec_rs_used),
        .dec_rt      (dec_rt),
        .dec_rt_used (dec_rt_used),
        .exe_valid   (exe_valid),
        .exe_wen     (exe_wen),
        .exe_load    (exe_load),
        .exe_rd      (exe_rd),
        .stall       (lu_stall)
    );

    assign sel_a        = opnd_sel[0];
    assign sel_b        = opnd_sel[1];
    assign freeze_front = lu_stall;
    assign bubble_exe   = lu_stall;

    // R6: with no live writer downstream, both operands read the register file
    a_r6_no_writer: assert property (@(posedge clk) disable iff (rst)
        (!early_live && !late_live) |-> (sel_a == 2'b00 && sel_b == 2'b00));

    // R7: an invalid decode slot never freezes the front end
    a_r7_invalid_dec: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |-> (!freeze_front && !bubble_exe));

endmodule

// File: tb/fwd_interlock_unit_bench.sv
module fwd_interlock_unit_bench;
    localparam int RW = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic          dec_valid, dec_rs_used, dec_rt_used;
    logic [RW-1:0] dec_rs, dec_rt;
    logic          exe_valid, exe_wen, exe_load;
    logic [RW-1:0] exe_rd, exe_rs, exe_rt;
    logic          mem_valid, mem_wen, wb_valid, wb_wen;
    logic [RW-1:0] mem_rd, wb_rd;
    logic [1:0]    sel_a, sel_b;
    logic          freeze_front, bubble_exe;

    int n_checks = 0;
    int n_fail   = 0;

    fwd_interlock_unit #(.REG_W(RW)) u_fwd_interlock_unit (
        .clk(clk), .rst(rst),
        .dec_valid(dec_valid), .dec_rs(dec_rs), .dec_rs_used(dec_rs_used),
        .dec_rt(dec_rt), .dec_rt_used(dec_rt_used),
        .exe_valid(exe_valid), .exe_wen(exe_wen), .exe_load(exe_load),
        .exe_rd(exe_rd), .exe_rs(exe_rs), .exe_rt(exe_rt),
        .mem_valid(mem_valid), .mem_wen(mem_wen), .mem_rd(mem_rd),
        .wb_valid(wb_valid), .wb_wen(wb_wen), .wb_rd(wb_rd),
        .sel_a(sel_a), .sel_b(sel_b),
        .freeze_front(freeze_front), .bubble_exe(bubble_exe)
    );

    // Reference: which source an operand should read, and the requirement it shows
    function automatic logic [1:0] ref_sel(input logic [RW-1:0] r, output string tag);
        bit m_ok = mem_valid && mem_wen;
        bit w_ok = wb_valid && wb_wen;
        tag = "R1";
        if (r == 0) begin
            tag = "R5";
            return 2'b00;
        end
        if (m_ok && mem_rd == r) begin
            tag = (w_ok && wb_rd == r) ? "R4" : "R2";
            return 2'b10;
        end
        if (w_ok && wb_rd == r) begin
            tag = "R3";
            return 2'b01;
        end
        if (mem_rd == r || wb_rd == r) tag = "R6";
        return 2'b00;
    endfunction

    function automatic bit ref_stall(output string tag);
        bit a_hit = dec_rs_used && dec_rs == exe_rd;
        bit b_hit = dec_rt_used && dec_rt == exe_rd;
        bit raw_hit = (dec_rs == exe_rd) || (dec_rt == exe_rd);
        tag = "R7";
        if (exe_rd == 0 && raw_hit) tag = "R5";
        else if (!exe_load && raw_hit) tag = "R9";
        else if ((!exe_valid || !exe_wen || !dec_valid) && raw_hit) tag = "R6";
        else if (raw_hit && !a_hit && !b_hit) tag = "R8";
        return dec_valid && exe_valid && exe_wen && exe_load && exe_rd != 0 && (a_hit || b_hit);
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string extra);
        string ta, tb_, ts;
        logic [1:0] ea, eb;
        bit es;
        ea = ref_sel(exe_rs, ta);
        eb = ref_sel(exe_rt, tb_);
        es = ref_stall(ts);
        check({ta, extra}, "sel_a", sel_a, ea);
        check({tb_, " R10", extra}, "sel_b", sel_b, eb);
        check({ts, extra}, "freeze_front", freeze_front, es);
        check({ts, extra}, "bubble_exe", bubble_exe, es);
    endtask

    task automatic idle();
        dec_valid = 0; dec_rs = 0; dec_rs_used = 0; dec_rt = 0; dec_rt_used = 0;
        exe_valid = 0; exe_wen = 0; exe_load = 0; exe_rd = 0; exe_rs = 0; exe_rt = 0;
        mem_valid = 0; mem_wen = 0; mem_rd = 0; wb_valid = 0; wb_wen = 0; wb_rd = 0;
    endtask

    task automatic step(input string extra);
        #2;
        compare_all(extra);
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset / idle state, all outputs at rest
        check("R1", "sel_a idle", sel_a, 0);
        check("R1", "sel_b idle", sel_b, 0);
        check("R1", "freeze idle", freeze_front, 0);
        check("R1", "bubble idle", bubble_exe, 0);
        @(negedge clk);

        // R2: adjacent ALU producer, no stall (R9)
        idle(); exe_valid = 1; exe_wen = 1; exe_rs = 3; exe_rt = 4;
        mem_valid = 1; mem_wen = 1; mem_rd = 3; step(" R2");
        // R3: producer two ahead, on operand B
        idle(); exe_valid = 1; exe_rs = 2; exe_rt = 6;
        wb_valid = 1; wb_wen = 1; wb_rd = 6; step(" R3");
        // R4: both stages write the same register
        idle(); exe_rs = 7; exe_rt = 7; mem_valid = 1; mem_wen = 1; mem_rd = 7;
        wb_valid = 1; wb_wen = 1; wb_rd = 7; step(" R4");
        // R5: register 0 everywhere
        idle(); mem_valid = 1; mem_wen = 1; wb_valid = 1; wb_wen = 1;
        dec_valid = 1; dec_rs_used = 1; exe_valid = 1; exe_wen = 1; exe_load = 1; step(" R5");
        // R6: disabled writers ignored
        idle(); exe_rs = 9; exe_rt = 10; mem_valid = 1; mem_rd = 9; wb_wen = 1; wb_rd = 10;
        step(" R6");
        // R8: match only on an unread source
        idle(); dec_valid = 1; dec_rs = 1; dec_rs_used = 1; dec_rt = 5; dec_rt_used = 0;
        exe_valid = 1; exe_wen = 1; exe_load = 1; exe_rd = 5; step(" R8");
        // R9: non-load producer followed by dependent instruction
        idle(); dec_valid = 1; dec_rs = 5; dec_rs_used = 1;
        exe_valid = 1; exe_wen = 1; exe_rd = 5; step(" R9");
        // R7: store-data operand depends on a load
        idle(); dec_valid = 1; dec_rs = 2; dec_rs_used = 1; dec_rt = 8; dec_rt_used = 1;
        exe_valid = 1; exe_wen = 1; exe_load = 1; exe_rd = 8; step(" R7");

        // R11: load, bubble, consumer sequence
        idle(); dec_valid = 1; dec_rs = 12; dec_rs_used = 1; dec_rt = 3; dec_rt_used = 1;
        exe_valid = 1; exe_wen = 1; exe_load = 1; exe_rd = 12; step(" R11 stall");
        exe_valid = 0; exe_load = 0; mem_valid = 1; mem_wen = 1; mem_rd = 12;
        step(" R11 bubble");
        dec_valid = 0; exe_valid = 1; exe_wen = 1; exe_rd = 13; exe_rs = 12; exe_rt = 3;
        mem_valid = 0; mem_wen = 0; mem_rd = 0;
        wb_valid = 1; wb_wen = 1; wb_rd = 12; step(" R11 bypass");
        check("R11", "sel_a after stall", sel_a, 2'b01);

        // Random sweep over a narrow register range to provoke matches
        for (int i = 0; i < 600; i++) begin
            dec_valid = 1'($urandom); dec_rs = RW'($urandom % 4); dec_rt = RW'($urandom % 4);
            dec_rs_used = 1'($urandom); dec_rt_used = 1'($urandom);
            exe_valid = 1'($urandom); exe_wen = 1'($urandom); exe_load = 1'($urandom);
            exe_rd = RW'($urandom % 4); exe_rs = RW'($urandom % 4); exe_rt = RW'($urandom % 4);
            mem_valid = 1'($urandom); mem_wen = 1'($urandom); mem_rd = RW'($urandom % 4);
            wb_valid = 1'($urandom); wb_wen = 1'($urandom); wb_rd = RW'($urandom % 4);
            step("");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule